// File: doc/BRIEF.md
# Li-ion Charge Cycle Controller

This block sequences the charge cycle of a single lithium cell. It works only on quantized measurements: the battery voltage and charge current arrive as integer millivolt and milliampere codes. From these, together with a set of enable and regulation flags, it decides whether a cycle is running. It picks the current phase (short-circuit recovery, precharge or fast charge) from voltage bands, terminates the cycle, and restarts it later. The analog loops and the switching converter are outside the block. It only hands them a phase selection and a battery FET enable.

It reports progress in three ways. A 2-bit status code gives the cycle state. A one-cycle strobe marks completion. An open-drain-style indicator output (1 = released) is low while charging, high when idle or finished, and blinks with a one-second period while a suspend fault is present. An overvoltage comparator against the regulation target stops charging at once and raises a battery fault flag.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: A cycle starts, and keeps running, only while all of these hold: the converter runs, the charge enable bit is 1, the active-low enable pin is 0, the fast-charge current code is nonzero, there is no safety timer fault, the battery FET is not forced off, and there is no battery fault. Removing any one of them returns the status to 00 on the next clock edge.
- R2: While charging, the phase output is 01 (short-circuit current) below 2000 mV, 10 (precharge) from 2000 mV up to the low-battery threshold, and 11 (fast charge) at or above it. The phase output is 00 when not charging.
- R3: The low-battery threshold is 3000 mV when the threshold select input is 0, and 2800 mV when it is 1.
- R4: A committed voltage band changes only after the new band has been seen on two consecutive clock edges. A one-cycle excursion into another band has no effect on the phase output.
- R5: The status code is 00 when not charging, 01 in short-circuit or precharge, 10 in fast charge, and 11 when the cycle is done.
- R6: The cycle terminates one edge after all of these hold in fast charge: the current is below the termination setting, the battery is above the recharge threshold, and termination is enabled. The status then becomes 11, the battery FET enable drops, and the done strobe is high for exactly one cycle.
- R7: Termination is suppressed while input regulation or thermal regulation is active, and while the termination enable is 0.
- R8: The recharge threshold is the regulation voltage minus 100 mV, or minus 200 mV when the wide select bit is 1. In the done state, a battery below it on two consecutive edges restarts charging.
- R9: The done state persists until recharge, or until the enable pin or the enable bit is toggled, which restarts the cycle.
- R10: A battery voltage above regulation + regulation/25 (integer division) sets the battery fault output on the next edge, and charging stops on the edge after.
- R11: The indicator is 0 while charging and 1 when idle or done. While a timer fault or battery fault is present, it toggles every HALF_CYC cycles. The indicator disable input forces it to 1.
- R12: The battery FET enable is 0 when it is forced off or when the cycle is done, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vbat_mv_i | input | VW | Battery voltage code, mV |
| ibat_ma_i | input | IW | Charge current code, mA |
| vreg_mv_i | input | VW | Regulation voltage target, mV |
| iterm_ma_i | input | IW | Termination current setting, mA |
| ichg_code_i | input | ICHG_W | Fast-charge current code; zero blocks charging |
| chg_en_i | input | 1 | Charge enable bit |
| ce_n_i | input | 1 | Active-low charge enable pin |
| conv_on_i | input | 1 | Converter running |
| in_dpm_i | input | 1 | Input voltage/current regulation active |
| therm_reg_i | input | 1 | Thermal regulation active |
| tmr_fault_i | input | 1 | Safety timer fault |
| fet_force_off_i | input | 1 | Battery FET forced off |
| term_en_i | input | 1 | Termination enable |
| rechg_wide_i | input | 1 | Recharge offset select: 0 = 100 mV, 1 = 200 mV |
| lowv_low_i | input | 1 | Low-battery threshold select: 0 = 3000 mV, 1 = 2800 mV |
| ind_dis_i | input | 1 | Indicator disable (forces released) |
| phase_o | output | 2 | Phase: 00 off, 01 short, 10 precharge, 11 fast |
| status_o | output | 2 | Cycle status code |
| fet_on_o | output | 1 | Battery FET enable |
| done_pulse_o | output | 1 | One-cycle termination strobe |
| bat_fault_o | output | 1 | Battery overvoltage fault |
| ind_n_o | output | 1 | Indicator drive, 1 = released |

## Verification
Each result has a fixed latency. A change of the start conditions or of the termination conditions shows up in the status one edge later. A new voltage band shows up in phase and status two edges later. Overvoltage raises the fault one edge later and clears the status the edge after that. Recharge needs two edges below the threshold. The bench drives inputs at the falling edge and advances an exact number of rising edges before it samples. For the latency-defining cases it also samples one edge early, to confirm that nothing has changed yet. The blink is checked by measuring complete run lengths of the indicator, and the expected phase for random voltages comes from a bench function of the band limits.

// File: rtl/chg_pkg.sv
`timescale 1ns/1ps
package chg_pkg;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_SHORT = 2'd1,
        PH_PRE   = 2'd2,
        PH_FAST  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHARGE = 2'd1,
        ST_DONE   = 2'd2
    } cyc_e;

    localparam logic [1:0] STS_OFF  = 2'b00;
    localparam logic [1:0] STS_PRE  = 2'b01;
    localparam logic [1:0] STS_FAST = 2'b10;
    localparam logic [1:0] STS_DONE = 2'b11;

    typedef struct packed {
        logic ovp;
        logic above_rechg;
        logic below_rechg;
    } thr_t;

    function automatic phase_e classify(input logic [31:0] v,
                                        input logic [31:0] short_lim,
                                        input logic [31:0] low_lim);
        if (v < short_lim)
            return PH_SHORT;
        else if (v < low_lim)
            return PH_PRE;
        else
            return PH_FAST;
    endfunction

    function automatic logic [1:0] status_of(input cyc_e st, input phase_e ph);
        case (st)
            ST_CHARGE: return (ph == PH_FAST) ? STS_FAST : STS_PRE;
            ST_DONE:   return STS_DONE;
            default:   return STS_OFF;
        endcase
    endfunction

endpackage

// File: rtl/chg_band_sel.sv
`timescale 1ns/1ps
module chg_band_sel
    import chg_pkg::*;
#(
    parameter int unsigned VW         = 16,
    parameter int unsigned SHORT_MV   = 2000,
    parameter int unsigned LOWV_HI_MV = 3000,
    parameter int unsigned LOWV_LO_MV = 2800
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [VW-1:0] vbat_mv_i,
    input  logic          lowv_low_i,
    output phase_e        band_o
);

    logic [31:0] low_lim;
    phase_e      raw;
    phase_e      raw_prev_q;
    phase_e      band_q;

    assign low_lim = lowv_low_i ? LOWV_LO_MV : LOWV_HI_MV;
    assign raw     = classify(32'(vbat_mv_i), SHORT_MV, low_lim);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            raw_prev_q <= PH_SHORT;
            band_q     <= PH_SHORT;
        end else begin
            raw_prev_q <= raw;
            if (raw == raw_prev_q)
                band_q <= raw;
        end
    end

    assign band_o = band_q;

    // R4
    band_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (band_q != $past(band_q)) |-> ($past(raw) == $past(raw_prev_q)));

endmodule

// File: rtl/chg_thresh.sv
`timescale 1ns/1ps
module chg_thresh
    import chg_pkg::*;
#(
    parameter int unsigned VW              = 16,
    parameter int unsigned OVP_DIV         = 25,
    parameter int unsigned RECHG_NARROW_MV = 100,
    parameter int unsigned RECHG_WIDE_MV   = 200
) (
    input  logic [VW-1:0] vbat_mv_i,
    input  logic [VW-1:0] vreg_mv_i,
    input  logic          rechg_wide_i,
    output thr_t          thr_o
);

    localparam int unsigned XW = VW + 1;
    localparam logic [XW-1:0] DIV_X    = XW'(OVP_DIV);
    localparam logic [XW-1:0] NARROW_X = XW'(RECHG_NARROW_MV);
    localparam logic [XW-1:0] WIDE_X   = XW'(RECHG_WIDE_MV);

    logic [XW-1:0] v_x;
    logic [XW-1:0] r_x;
    logic [XW-1:0] ovp_lim;
    logic [XW-1:0] off_x;
    logic [XW-1:0] rechg_lim;

    assign v_x       = {1'b0, vbat_mv_i};
    assign r_x       = {1'b0, vreg_mv_i};
    assign ovp_lim   = r_x + (r_x / DIV_X);
    assign off_x     = rechg_wide_i ? WIDE_X : NARROW_X;
    assign rechg_lim = (r_x > off_x) ? (r_x - off_x) : '0;

    assign thr_o.ovp         = v_x > ovp_lim;
    assign thr_o.above_rechg = v_x > rechg_lim;
    assign thr_o.below_rechg = v_x < rechg_lim;

endmodule

// File: rtl/chg_blink.sv
`timescale 1ns/1ps
module chg_blink #(
    parameter int unsigned HALF_CYC = 125_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fault_i,
    output logic lvl_o
);

    localparam int unsigned CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !fault_i) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign lvl_o = lvl_q;

    // R11
    blink_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (fault_i && $past(fault_i) && (lvl_q != $past(lvl_q))) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/chg_cycle_ctrl.sv
`timescale 1ns/1ps
module chg_cycle_ctrl
    import chg_pkg::*;
#(
    parameter int unsigned VW              = 16,
    parameter int unsigned IW              = 16,
    parameter int unsigned ICHG_W          = 6,
    parameter int unsigned SHORT_MV        = 2000,
    parameter int unsigned LOWV_HI_MV      = 3000,
    parameter int unsigned LOWV_LO_MV      = 2800,
    parameter int unsigned RECHG_NARROW_MV = 100,
    parameter int unsigned RECHG_WIDE_MV   = 200,
    parameter int unsigned OVP_DIV         = 25,
    parameter int unsigned HALF_CYC        = 125_000_000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [VW-1:0]     vbat_mv_i,
    input  logic [IW-1:0]     ibat_ma_i,
    input  logic [VW-1:0]     vreg_mv_i,
    input  logic [IW-1:0]     iterm_ma_i,
    input  logic [ICHG_W-1:0] ichg_code_i,
    input  logic              chg_en_i,
    input  logic              ce_n_i,
    input  logic              conv_on_i,
    input  logic              in_dpm_i,
    input  logic              therm_reg_i,
    input  logic              tmr_fault_i,
    input  logic              fet_force_off_i,
    input  logic              term_en_i,
    input  logic              rechg_wide_i,
    input  logic              lowv_low_i,
    input  logic              ind_dis_i,
    output logic [1:0]        phase_o,
    output logic [1:0]        status_o,
    output logic              fet_on_o,
    output logic              done_pulse_o,
    output logic              bat_fault_o,
    output logic              ind_n_o
);

    phase_e band;
    thr_t   thr;
    cyc_e   state_q;
    cyc_e   state_d;
    logic   bat_fault_q;
    logic   low_prev_q;
    logic   done_q;
    logic   start_ok;
    logic   term_now;
    logic   fault_any;
    logic   blink_lvl;

    chg_band_sel #(
        .VW(VW), .SHORT_MV(SHORT_MV),
        .LOWV_HI_MV(LOWV_HI_MV), .LOWV_LO_MV(LOWV_LO_MV)
    ) band_i (
        .clk_i(clk_i), .rst_i(rst_i),
        .vbat_mv_i(vbat_mv_i), .lowv_low_i(lowv_low_i),
        .band_o(band)
    );

    chg_thresh #(
        .VW(VW), .OVP_DIV(OVP_DIV),
        .RECHG_NARROW_MV(RECHG_NARROW_MV), .RECHG_WIDE_MV(RECHG_WIDE_MV)
    ) thr_i (
        .vbat_mv_i(vbat_mv_i), .vreg_mv_i(vreg_mv_i),
        .rechg_wide_i(rechg_wide_i), .thr_o(thr)
    );

    assign fault_any = tmr_fault_i | bat_fault_q;

    chg_blink #(.HALF_CYC(HALF_CYC)) blink_i (
        .clk_i(clk_i), .rst_i(rst_i),
        .fault_i(fault_any), .lvl_o(blink_lvl)
    );

    assign start_ok = conv_on_i & chg_en_i & ~ce_n_i & (|ichg_code_i)
                    & ~tmr_fault_i & ~fet_force_off_i & ~bat_fault_q;

    assign term_now = (band == PH_FAST) & (ibat_ma_i < iterm_ma_i)
                    & thr.above_rechg & term_en_i & ~in_dpm_i & ~therm_reg_i;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_CHARGE;
            ST_CHARGE: begin
                if (!start_ok)     state_d = ST_IDLE;
                else if (term_now) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (!start_ok)                             state_d = ST_IDLE;
                else if (thr.below_rechg && low_prev_q)    state_d = ST_CHARGE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q     <= ST_IDLE;
            bat_fault_q <= 1'b0;
            low_prev_q  <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            bat_fault_q <= thr.ovp;
            low_prev_q  <= thr.below_rechg;
            done_q      <= (state_q == ST_CHARGE) && (state_d == ST_DONE);
        end
    end

    assign phase_o      = (state_q == ST_CHARGE) ? band : PH_OFF;
    assign status_o     = status_of(state_q, band);
    assign fet_on_o     = ~fet_force_off_i & (state_q != ST_DONE);
    assign done_pulse_o = done_q;
    assign bat_fault_o  = bat_fault_q;

    always_comb begin
        if (ind_dis_i)
            ind_n_o = 1'b1;
        else if (fault_any)
            ind_n_o = blink_lvl;
        else
            ind_n_o = (state_q != ST_CHARGE);
    end

    // R1
    start_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_CHARGE && $past(state_q) == ST_IDLE) |-> $past(start_ok));

    // R6
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_pulse_o |-> (status_o == STS_DONE && !fet_on_o));

    // R7
    no_term_reg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_CHARGE && (in_dpm_i || therm_reg_i || !term_en_i)) |=> (state_q != ST_DONE));

    // R10
    ovp_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bat_fault_q |=> (state_q == ST_IDLE));

endmodule

// File: tb/chg_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module chg_cycle_ctrl_tb_top;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] vbat = 16'd3700;
    logic [15:0] ibat = 16'd1000;
    logic [15:0] vreg = 16'd4208;
    logic [15:0] iterm = 16'd256;
    logic [5:0]  ichg = 6'd10;
    logic chg_en = 1'b1, ce_n = 1'b1, conv_on = 1'b1, in_dpm = 1'b0, therm = 1'b0;
    logic tmr_fault = 1'b0, fet_off = 1'b0, term_en = 1'b1, rechg_wide = 1'b0;
    logic lowv_low = 1'b0, ind_dis = 1'b0;
    logic [1:0] phase, status;
    logic fet_on, done_p, bat_fault, ind_n;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    chg_cycle_ctrl #(.HALF_CYC(HALF)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .vbat_mv_i(vbat), .ibat_ma_i(ibat), .vreg_mv_i(vreg), .iterm_ma_i(iterm),
        .ichg_code_i(ichg), .chg_en_i(chg_en), .ce_n_i(ce_n), .conv_on_i(conv_on),
        .in_dpm_i(in_dpm), .therm_reg_i(therm), .tmr_fault_i(tmr_fault),
        .fet_force_off_i(fet_off), .term_en_i(term_en), .rechg_wide_i(rechg_wide),
        .lowv_low_i(lowv_low), .ind_dis_i(ind_dis),
        .phase_o(phase), .status_o(status), .fet_on_o(fet_on),
        .done_pulse_o(done_p), .bat_fault_o(bat_fault), .ind_n_o(ind_n)
    );

    function automatic logic [1:0] exp_phase(input int v, input logic low);
        int lim;
        lim = low ? 2800 : 3000;
        if (v < 2000)     return 2'b01;
        else if (v < lim) return 2'b10;
        else              return 2'b11;
    endfunction

    function automatic logic [1:0] exp_status(input logic [1:0] ph);
        return (ph == 2'b11) ? 2'b10 : 2'b01;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic block(input int k, input logic b);
        case (k)
            0: conv_on = ~b;
            1: chg_en = ~b;
            2: ce_n = b;
            3: ichg = b ? 6'd0 : 6'd10;
            4: tmr_fault = b;
            default: fet_off = b;
        endcase
    endtask

    task automatic measure_run(input string req);
        logic prev;
        int run;
        prev = ind_n;
        for (int i = 0; i < 40 && ind_n == prev; i++) cyc(1);
        prev = ind_n;
        run = 0;
        while (ind_n == prev && run < 40) begin
            cyc(1);
            run++;
        end
        chk(req, run, HALF);
    endtask

    initial begin
        #800000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        rst = 1'b0;
        cyc(3);
        // R5 reset / idle state
        chk("R5 idle status", status, 0);
        chk("R2 idle phase", phase, 0);
        chk("R11 idle indicator", ind_n, 1);
        chk("R12 idle fet", fet_on, 1);
        chk("R6 idle strobe", done_p, 0);

        // R1 start gating
        ce_n = 1'b0;
        cyc(1);
        chk("R1 start", status, 2);
        chk("R11 charging indicator", ind_n, 0);
        for (int k = 0; k < 6; k++) begin
            block(k, 1'b1);
            cyc(1);
            chk("R1 blocked", status, 0);
            if (k == 5) chk("R12 forced off", fet_on, 0);
            block(k, 1'b0);
            cyc(1);
            chk("R1 resumed", status, 2);
        end

        // R2 R3 directed boundaries
        begin
            int bv[6] = '{1999, 2000, 2999, 3000, 2799, 2800};
            logic bl[6] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
            for (int i = 0; i < 6; i++) begin
                vbat = 16'(bv[i]);
                lowv_low = bl[i];
                cyc(3);
                chk("R2 R3 boundary phase", phase, exp_phase(bv[i], bl[i]));
                chk("R5 boundary status", status, exp_status(exp_phase(bv[i], bl[i])));
            end
        end

        // R2 R3 random bands
        for (int i = 0; i < 40; i++) begin
            int v;
            v = 1500 + int'($urandom_range(0, 2700));
            vbat = 16'(v);
            lowv_low = 1'($urandom_range(0, 1));
            cyc(3);
            chk("R2 random phase", phase, exp_phase(v, lowv_low));
            chk("R5 random status", status, exp_status(exp_phase(v, lowv_low)));
        end
        lowv_low = 1'b0;

        // R4 hysteresis
        vbat = 16'd3700;
        cyc(3);
        vbat = 16'd2500;
        cyc(1);
        vbat = 16'd3700;
        cyc(1);
        chk("R4 glitch ignored", phase, 3);
        cyc(2);
        chk("R4 glitch ignored later", phase, 3);
        vbat = 16'd2500;
        cyc(1);
        chk("R4 one sample", phase, 3);
        cyc(1);
        chk("R4 two samples", phase, 2);

        // R6 termination
        vbat = 16'd4150;
        cyc(3);
        chk("R6 pre-term", status, 2);
        ibat = 16'd200;
        cyc(1);
        chk("R6 done status", status, 3);
        chk("R6 strobe", done_p, 1);
        chk("R6 fet off", fet_on, 0);
        chk("R11 done indicator", ind_n, 1);
        chk("R2 done phase", phase, 0);
        cyc(1);
        chk("R6 strobe one cycle", done_p, 0);
        chk("R6 done held", status, 3);

        // R8 recharge narrow
        vbat = 16'd4050;
        cyc(1);
        chk("R8 one sample", status, 3);
        cyc(1);
        chk("R8 recharge", status, 2);
        // R8 wide offset
        rechg_wide = 1'b1;
        cyc(1);
        chk("R8 wide term", status, 3);
        vbat = 16'd4020;
        cyc(3);
        chk("R8 wide above", status, 3);
        vbat = 16'd4000;
        cyc(1);
        chk("R8 wide one sample", status, 3);
        cyc(1);
        chk("R8 wide recharge", status, 2);

        // R7 suppression
        in_dpm = 1'b1;
        vbat = 16'd4150;
        cyc(3);
        chk("R7 input regulation", status, 2);
        in_dpm = 1'b0;
        therm = 1'b1;
        cyc(2);
        chk("R7 thermal regulation", status, 2);
        therm = 1'b0;
        term_en = 1'b0;
        cyc(2);
        chk("R7 term disabled", status, 2);
        term_en = 1'b1;
        cyc(1);
        chk("R7 term released", status, 3);

        // R9 hold and restart by toggle
        ibat = 16'd1000;
        cyc(3);
        chk("R9 done persists", status, 3);
        ce_n = 1'b1;
        cyc(1);
        chk("R9 pin toggle off", status, 0);
        ce_n = 1'b0;
        cyc(1);
        chk("R9 pin restart", status, 2);
        ibat = 16'd200;
        cyc(1);
        chk("R9 done again", status, 3);
        ibat = 16'd1000;
        chg_en = 1'b0;
        cyc(1);
        chk("R9 bit toggle off", status, 0);
        chg_en = 1'b1;
        cyc(1);
        chk("R9 bit restart", status, 2);

        // R10 overvoltage
        vbat = 16'd4376;
        cyc(3);
        chk("R10 at limit", bat_fault, 0);
        chk("R10 at limit status", status, 2);
        vbat = 16'd4377;
        cyc(1);
        chk("R10 fault", bat_fault, 1);
        chk("R10 not yet stopped", status, 2);
        cyc(1);
        chk("R10 stopped", status, 0);

        // R11 blink and disable
        measure_run("R11 blink run");
        measure_run("R11 blink run");
        ind_dis = 1'b1;
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 20; i++) begin
                cyc(1);
                if (ind_n == 1'b0) lows++;
            end
            chk("R11 disabled", lows, 0);
        end
        ind_dis = 1'b0;
        vbat = 16'd3700;
        cyc(3);
        chk("R10 fault cleared", bat_fault, 0);
        chk("R10 restart", status, 2);
        chk("R11 charging again", ind_n, 0);
        tmr_fault = 1'b1;
        measure_run("R11 timer blink run");
        chk("R1 timer fault stop", status, 0);
        tmr_fault = 1'b0;
        cyc(2);

        // R12
        fet_off = 1'b1;
        cyc(1);
        chk("R12 forced off", fet_on, 0);
        chk("R1 forced off stop", status, 0);
        fet_off = 1'b0;
        cyc(1);
        chk("R12 released", fet_on, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule